// File: doc/BRIEF.md
# Receive Descriptor Ownership Sequencer

This block decides where the bytes of an incoming frame are stored in host memory. Host memory holds a ring of receive descriptors. Each descriptor is one word with an ownership flag, three status flags, a byte-count field and a buffer-length field. The block keeps a cached copy of the current descriptor and of the one after it, together with an ownership flag for each. It reads a descriptor from memory only when the cached ownership does not already show that the descriptor belongs to the block.

When a frame's address has been accepted, the sequencer first makes sure it owns the current buffer. If it does not, it reads the current descriptor one last time and counts the frame as missed when the host still owns it. Once it owns the current buffer, it learns the ownership of the next descriptor and then starts accepting data beats, one byte per beat. When a buffer fills and more data follows, the sequencer does one of two things:
- If it owns the next buffer, it hands back the filled descriptor by clearing only its ownership bit, and the frame continues in the next buffer.
- If it does not own the next buffer, it returns the current descriptor with error flags set and discards the rest of the frame.

At the end of the frame it writes the end-of-packet flag and the total byte count into the last descriptor, moves the cached next descriptor into the current position, and reads ahead one more descriptor.

Descriptor memory is reached through one request/grant port. The request stays up until it is granted. Read data is valid in the grant cycle, and a write takes effect in the grant cycle.

Top module: `rx_desc_seq`

## Requirements
- R1: Descriptor word layout, with L = LEN_W:
  - bits [L-1:0]: buffer length.
  - bits [2L-1:L]: byte count.
  - bit 2L: overflow.
  - bit 2L+1: buffer error.
  - bit 2L+2: end of packet.
  - bit 2L+3: ownership (1 = owned by the block).

  Every descriptor write the block issues has the ownership bit at 0.
- R2: A `frm_start` while the cached current ownership is lacking causes exactly one read of the current descriptor. If that read shows host ownership:
  - `missed_flag` is set and `missed_cnt` increments.
  - No further descriptor access occurs until `frm_end`.
  - `cur_idx` is unchanged.
- R3: `missed_cnt` saturates at 2^CNT_W-1. A `miss_clr` pulse zeroes both `missed_cnt` and `missed_flag`. If the clear falls in the same cycle as a miss, the result is a count of 1 with the flag set.
- R4: Once current ownership is confirmed, the next descriptor is read when its cached ownership is lacking. `beat_rdy` then rises whatever that ownership is.
- R5: If the cached current and next descriptors are both owned, `frm_start` causes no descriptor access, and `beat_rdy` is high in the following cycle.
- R6: A beat that arrives while the current buffer is full, with the next descriptor owned, has these effects:
  - The current descriptor is written back unchanged except for a cleared ownership bit.
  - The beat is stored as the first byte of the next buffer.
  - The descriptor after that is read ahead.
- R7: A beat that arrives while the current buffer is full, with the next descriptor not owned, has these effects:
  - The current descriptor is written with ownership 0, buffer error 1, overflow 1, end of packet 0, the byte count equal to the bytes stored, and the length preserved.
  - The remaining beats are discarded.
  - At `frm_end` the ring advances by one descriptor.
- R8: At the end of a frame without error, the last descriptor is written with ownership 0, end of packet 1, the total frame byte count and the length preserved. The cached next descriptor becomes current, and the descriptor after it is read ahead.
- R9: `cur_idx` advances only in steps of one and wraps from RING-1 to 0.
- R10: An ungranted request holds `desc_req`, `desc_idx`, `desc_we` and `desc_wdata` stable until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Pulse: a frame's address has been accepted |
| frm_beat | input | 1 | Pulse: one data byte, taken only while beat_rdy is high |
| frm_end | input | 1 | Pulse: last byte of the frame has arrived |
| beat_rdy | output | 1 | Data beats are being taken (stored or discarded) |
| desc_req | output | 1 | Descriptor access request |
| desc_we | output | 1 | Access is a write |
| desc_idx | output | $clog2(RING) | Ring index of the accessed descriptor |
| desc_wdata | output | 2*LEN_W+4 | Descriptor word to write |
| desc_gnt | input | 1 | Access granted this cycle |
| desc_rdata | input | 2*LEN_W+4 | Descriptor word read, valid with grant |
| miss_clr | input | 1 | Pulse: clear missed-frame count and flag |
| missed_flag | output | 1 | Sticky missed-frame indication |
| missed_cnt | output | CNT_W | Saturating missed-frame counter |
| cur_idx | output | $clog2(RING) | Ring index of the current descriptor |

## Verification
The host's clear of the missed-frame state and the increment from a failed final poll can land on the same clock edge. The bench lines this up by issuing `frm_start` on a ring slot the host owns, with grants always enabled, so the final poll completes on the second edge after the start pulse. It raises `miss_clr` for exactly that edge and expects a count of one with the flag still set, then clears again on its own and expects zeros. A second timing overlap is a held request with the grant withheld. The bench checks at the ports that the access stays unchanged and that no data beats are taken until the grant arrives.

// File: rtl/rx_desc_seq.sv
module rx_desc_seq #(
  parameter int RING  = 8,
  parameter int LEN_W = 12,
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frm_start,
  input  logic                       frm_beat,
  input  logic                       frm_end,
  output logic                       beat_rdy,
  output logic                       desc_req,
  output logic                       desc_we,
  output logic [$clog2(RING)-1:0]    desc_idx,
  output logic [2*LEN_W+3:0]         desc_wdata,
  input  logic                       desc_gnt,
  input  logic [2*LEN_W+3:0]         desc_rdata,
  input  logic                       miss_clr,
  output logic                       missed_flag,
  output logic [CNT_W-1:0]           missed_cnt,
  output logic [$clog2(RING)-1:0]    cur_idx
);
  localparam int IW  = $clog2(RING);
  localparam int DW  = 2*LEN_W + 4;
  localparam int OWN = DW - 1;
  localparam int OVF = 2*LEN_W;
  localparam logic [CNT_W-1:0] MAXC = '1;

  typedef enum logic [3:0] {
    S_IDLE, S_PCUR, S_PNXT, S_XFER, S_HAND, S_LOOK,
    S_WERR, S_DROP, S_WEND, S_LOOKE, S_MISS
  } st_t;

  st_t st;
  logic [DW-1:0]    cur_w, nxt_w;
  logic             cur_own, nxt_own;
  logic [LEN_W-1:0] buf_cnt, frm_cnt;
  logic             end_pend;

  wire              fin      = frm_end | end_pend;
  wire [LEN_W-1:0]  cur_len  = cur_w[LEN_W-1:0];
  wire              is_wr    = (st == S_HAND) || (st == S_WERR) || (st == S_WEND);
  wire              miss_inc = (st == S_PCUR) && desc_gnt && !desc_rdata[OWN];
  wire [IW-1:0]     nxt_idx  = cur_idx + 1'b1;

  assign desc_req = (st == S_PCUR) || (st == S_PNXT) || (st == S_LOOK) ||
                    (st == S_LOOKE) || is_wr;
  assign desc_we  = is_wr;
  assign desc_idx = ((st == S_PCUR) || is_wr) ? cur_idx : nxt_idx;
  assign beat_rdy = (st == S_XFER) || (st == S_DROP);

  always_comb begin
    case (st)
      S_HAND:  desc_wdata = {1'b0, cur_w[DW-2:0]};
      S_WEND:  desc_wdata = {4'b0100, frm_cnt, cur_len};
      S_WERR:  desc_wdata = {4'b0011, frm_cnt, cur_len};
      default: desc_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cur_idx     <= '0;
      cur_w       <= '0;
      nxt_w       <= '0;
      cur_own     <= 1'b0;
      nxt_own     <= 1'b0;
      buf_cnt     <= '0;
      frm_cnt     <= '0;
      end_pend    <= 1'b0;
      missed_flag <= 1'b0;
      missed_cnt  <= '0;
    end else begin
      if (miss_clr)
        missed_cnt <= miss_inc ? CNT_W'(1) : '0;
      else if (miss_inc && missed_cnt != MAXC)
        missed_cnt <= missed_cnt + 1'b1;
      if (miss_inc)
        missed_flag <= 1'b1;
      else if (miss_clr)
        missed_flag <= 1'b0;

      if (st != S_IDLE && frm_end)
        end_pend <= 1'b1;

      case (st)
        S_IDLE: if (frm_start) begin
          buf_cnt  <= '0;
          frm_cnt  <= '0;
          end_pend <= 1'b0;
          if (!cur_own)      st <= S_PCUR;
          else if (!nxt_own) st <= S_PNXT;
          else               st <= S_XFER;
        end
        S_PCUR: if (desc_gnt) begin
          cur_w <= desc_rdata;
          if (desc_rdata[OWN]) begin
            cur_own <= 1'b1;
            st      <= nxt_own ? S_XFER : S_PNXT;
          end else begin
            st <= S_MISS;
          end
        end
        S_PNXT: if (desc_gnt) begin
          nxt_w   <= desc_rdata;
          nxt_own <= desc_rdata[OWN];
          st      <= S_XFER;
        end
        S_XFER: begin
          if (frm_beat) begin
            if (buf_cnt < cur_len) begin
              buf_cnt <= buf_cnt + 1'b1;
              frm_cnt <= frm_cnt + 1'b1;
            end else if (nxt_own) begin
              buf_cnt <= LEN_W'(1);
              frm_cnt <= frm_cnt + 1'b1;
              st      <= S_HAND;
            end else begin
              st <= S_WERR;
            end
          end else if (fin) begin
            end_pend <= 1'b0;
            st       <= S_WEND;
          end
        end
        S_HAND: if (desc_gnt) begin
          cur_idx <= nxt_idx;
          cur_w   <= nxt_w;
          cur_own <= 1'b1;
          nxt_own <= 1'b0;
          st      <= S_LOOK;
        end
        S_LOOK: if (desc_gnt) begin
          nxt_w   <= desc_rdata;
          nxt_own <= desc_rdata[OWN];
          st      <= S_XFER;
        end
        S_WERR: if (desc_gnt) st <= S_DROP;
        S_DROP: if (fin) begin
          end_pend <= 1'b0;
          cur_idx  <= nxt_idx;
          cur_w    <= nxt_w;
          cur_own  <= nxt_own;
          nxt_own  <= 1'b0;
          st       <= S_LOOKE;
        end
        S_WEND: if (desc_gnt) begin
          cur_idx <= nxt_idx;
          cur_w   <= nxt_w;
          cur_own <= nxt_own;
          nxt_own <= 1'b0;
          st      <= S_LOOKE;
        end
        S_LOOKE: if (desc_gnt) begin
          nxt_w   <= desc_rdata;
          nxt_own <= desc_rdata[OWN];
          st      <= S_IDLE;
        end
        S_MISS: if (fin) begin
          end_pend <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_WR_OWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req && desc_we |-> !desc_wdata[OWN]); // R1
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_MISS |-> !desc_req); // R2
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    missed_cnt == MAXC && !miss_clr |=> missed_cnt == MAXC); // R3
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    miss_clr |=> missed_cnt <= CNT_W'(1)); // R3
  AST_RDY_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    beat_rdy |-> !desc_req); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    cur_idx != $past(cur_idx) |-> cur_idx == IW'($past(cur_idx) + 1'b1)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req && !desc_gnt |=> desc_req && $stable(desc_idx) && $stable(desc_we)
                              && $stable(desc_wdata)); // R10
  AST_OVF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req && desc_we && desc_wdata[OVF] |-> desc_wdata[OVF+1]); // R7
endmodule

// File: tb/sim_rx_desc_seq.sv
module sim_rx_desc_seq;
  localparam int RING = 8, LW = 12, CW = 3, DW = 2*LW + 4, IW = 3;

  logic clk = 0, rst_n = 0;
  logic frm_start = 0, frm_beat = 0, frm_end = 0, miss_clr = 0, gnt_en = 1;
  logic beat_rdy, desc_req, desc_we, desc_gnt, missed_flag;
  logic [IW-1:0] desc_idx, cur_idx;
  logic [DW-1:0] desc_wdata, desc_rdata;
  logic [CW-1:0] missed_cnt;
  logic [DW-1:0] mem [RING];
  logic h_we = 0;
  logic [IW-1:0] h_idx = '0;
  logic [DW-1:0] h_val = '0;
  int n_rd = 0, n_wr = 0, n_badwr = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rx_desc_seq #(.RING(RING), .LEN_W(LW), .CNT_W(CW)) u0 (
    .clk, .rst_n, .frm_start, .frm_beat, .frm_end, .beat_rdy,
    .desc_req, .desc_we, .desc_idx, .desc_wdata, .desc_gnt, .desc_rdata,
    .miss_clr, .missed_flag, .missed_cnt, .cur_idx);

  assign desc_gnt   = desc_req & gnt_en;
  assign desc_rdata = mem[desc_idx];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RING; i++) mem[i] <= '0;
    end else begin
      if (h_we) mem[h_idx] <= h_val;
      if (desc_req && desc_gnt) begin
        if (desc_we) begin
          mem[desc_idx] <= desc_wdata;
          n_wr <= n_wr + 1;
          if (desc_wdata[DW-1]) n_badwr <= n_badwr + 1;
        end else n_rd <= n_rd + 1;
      end
    end
  end

  function automatic logic [DW-1:0] w(bit own, bit eop, bit ber, bit ovf, int cnt, int len);
    return {own, eop, ber, ovf, LW'(cnt), LW'(len)};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_set(int idx, logic [DW-1:0] val);
    h_we = 1; h_idx = IW'(idx); h_val = val;
    @(negedge clk); h_we = 0;
  endtask

  task automatic send_rest(int nb);
    int sent = 0, waits = 0;
    while (sent < nb && waits < 40) begin
      if (beat_rdy) begin
        frm_beat = 1; @(negedge clk); frm_beat = 0; sent++;
      end else begin
        @(negedge clk); waits++;
      end
    end
    frm_end = 1; @(negedge clk); frm_end = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_frame(int nb);
    frm_start = 1; @(negedge clk); frm_start = 0;
    send_rest(nb);
  endtask

  task automatic t_reset;
    chk(cur_idx == 0, "R9", "reset cur_idx", cur_idx, 0);
    chk(missed_cnt == 0 && !missed_flag, "R3", "reset miss state", missed_cnt, 0);
    chk(!desc_req && !beat_rdy, "R10", "reset idle", desc_req, 0);
  endtask

  task automatic t_miss;
    int r0 = n_rd, w0 = n_wr;
    run_frame(3);
    chk(n_rd - r0 == 1, "R2", "single final poll", n_rd - r0, 1);
    chk(n_wr == w0, "R2", "no write on miss", n_wr - w0, 0);
    chk(missed_flag && missed_cnt == 1, "R2", "miss counted", missed_cnt, 1);
    chk(cur_idx == 0, "R2", "index held", cur_idx, 0);
  endtask

  task automatic t_clear_collide;
    miss_clr = 1; @(negedge clk); miss_clr = 0;
    chk(missed_cnt == 0 && !missed_flag, "R3", "plain clear", missed_cnt, 0);
    frm_start = 1; @(negedge clk); frm_start = 0; miss_clr = 1;
    @(negedge clk); miss_clr = 0;
    chk(missed_cnt == 1, "R3", "clear with miss count", missed_cnt, 1);
    chk(missed_flag, "R3", "clear with miss flag", missed_flag, 1);
    send_rest(0);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 8; i++) run_frame(0);
    chk(missed_cnt == 7, "R3", "saturated count", missed_cnt, 7);
    miss_clr = 1; @(negedge clk); miss_clr = 0;
    chk(missed_cnt == 0 && !missed_flag, "R3", "clear after saturation", missed_cnt, 0);
  endtask

  task automatic t_single;
    int r0, w0;
    host_set(0, w(1, 0, 0, 0, 0, 10));
    r0 = n_rd; w0 = n_wr;
    run_frame(5);
    chk(mem[0] == w(0, 1, 0, 0, 5, 10), "R8", "final status word", mem[0], w(0, 1, 0, 0, 5, 10));
    chk(n_rd - r0 == 3 && n_wr - w0 == 1, "R4", "poll cur+next+lookahead", n_rd - r0, 3);
    chk(cur_idx == 1, "R8", "promoted index", cur_idx, 1);
  endtask

  task automatic t_cached;
    int r0;
    host_set(1, w(1, 0, 0, 0, 0, 20));
    host_set(2, w(1, 0, 0, 0, 0, 20));
    host_set(3, w(1, 0, 0, 0, 0, 4));
    host_set(4, w(1, 0, 0, 0, 0, 4));
    host_set(5, w(1, 0, 0, 0, 0, 4));
    run_frame(3);
    r0 = n_rd;
    frm_start = 1; @(negedge clk); frm_start = 0;
    chk(beat_rdy && n_rd == r0 && !desc_req, "R5", "no poll when both cached", n_rd - r0, 0);
    send_rest(2);
    chk(mem[2] == w(0, 1, 0, 0, 2, 20), "R8", "second frame status", mem[2], w(0, 1, 0, 0, 2, 20));
    chk(cur_idx == 3, "R8", "index after two frames", cur_idx, 3);
  endtask

  task automatic t_chain;
    int r0 = n_rd, w0 = n_wr;
    run_frame(10);
    chk(mem[3] == w(0, 0, 0, 0, 0, 4), "R6", "first chained handback", mem[3], w(0, 0, 0, 0, 0, 4));
    chk(mem[4] == w(0, 0, 0, 0, 0, 4), "R6", "second chained handback", mem[4], w(0, 0, 0, 0, 0, 4));
    chk(mem[5] == w(0, 1, 0, 0, 10, 4), "R8", "chain end status", mem[5], w(0, 1, 0, 0, 10, 4));
    chk(n_rd - r0 == 3 && n_wr - w0 == 3, "R6", "lookahead reads", n_rd - r0, 3);
    chk(cur_idx == 6, "R6", "index after chain", cur_idx, 6);
  endtask

  task automatic t_buferr;
    int w0;
    host_set(6, w(1, 0, 0, 0, 0, 3));
    w0 = n_wr;
    run_frame(6);
    chk(mem[6] == w(0, 0, 1, 1, 3, 3), "R7", "error status word", mem[6], w(0, 0, 1, 1, 3, 3));
    chk(n_wr - w0 == 1, "R7", "single error write", n_wr - w0, 1);
    chk(cur_idx == 7, "R7", "ring advanced", cur_idx, 7);
  endtask

  task automatic t_wrap_stall;
    host_set(7, w(1, 0, 0, 0, 0, 8));
    host_set(0, w(1, 0, 0, 0, 0, 8));
    gnt_en = 0;
    frm_start = 1; @(negedge clk); frm_start = 0;
    repeat (4) @(negedge clk);
    chk(desc_req && !desc_we && desc_idx == 7 && !beat_rdy, "R10", "held request", desc_idx, 7);
    gnt_en = 1;
    send_rest(2);
    chk(mem[7] == w(0, 1, 0, 0, 2, 8), "R8", "status before wrap", mem[7], w(0, 1, 0, 0, 2, 8));
    chk(cur_idx == 0, "R9", "wrap to zero", cur_idx, 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_miss();
    t_clear_collide();
    t_saturate();
    t_single();
    t_cached();
    t_chain();
    t_buferr();
    t_wrap_stall();
    chk(n_badwr == 0 && n_wr > 0, "R1", "ownership cleared on writes", n_badwr, 0);
    summary();
  end
endmodule